// File: doc/BRIEF.md
# Sticky Dual-Run Sequence Detector

This block watches a single serial bit stream, taking one bit on every rising clock edge. It raises its flag once the stream has shown both a pair of equal low bits on consecutive cycles and a pair of equal high bits on consecutive cycles. The two pairs may come in either order and may be any distance apart. Once raised, the flag stays up whatever later bits arrive. Only a synchronous reset lowers it again.

The block is a Moore machine with eight states, which is the fewest that give this behaviour. The flag is decoded from the state register alone. It is therefore glitch-free and changes only at clock edges. A typical use is as a qualifier: it tells downstream logic that a line has been seen holding steady at both levels.

Top module: `dual_run_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the machine returns to its initial state, and `hit` reads 0 immediately after that edge.
- R2: A stream that shows a high pair first and a low pair later (for example 1100) drives `hit` to 1.
- R3: A stream that shows a low pair first and a high pair later (for example 0011) drives `hit` to 1.
- R4: Once `hit` is 1, it stays 1 on every later cycle until reset, for any values of `din`.
- R5: `hit` becomes 1 right after the rising edge that samples the bit completing the second required pair, and not before.
- R6: A strictly alternating stream (0101... or 1010...) never drives `hit` to 1.
- R7: A stream containing only one kind of pair (for example 0001010100) leaves `hit` at 0.
- R8: Runs longer than two count as containing the pair, and extra repeated bits do not cause progress to be lost (for example 000111 and 1111010000 both drive `hit` to 1).
- R9: The two pairs may be separated by any number of alternating bits (for example 00101011 drives `hit` to 1 on its final bit).
- R10: Asserting `rst` after `hit` has risen clears `hit` to 0, and the detection starts over with no pair remembered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data bit, sampled each rising edge |
| hit | output | 1 | Sticky flag: both a low pair and a high pair have been seen |

## Verification
Every result of this block is due one edge after the bit that causes it. The bit sampled at an edge decides the state, and therefore `hit`, that is visible right after that same edge. The bench drives each bit between edges. It advances its reference model on the rising edge that samples the bit, and compares `hit` a short delay after that edge, before the next bit is driven. Reset is handled the same way: the zero flag is checked just after the edge that sampled `rst` high.

// File: rtl/dual_run_detector.sv
module dual_run_detector (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LAST0 = 3'd1,
    S_LAST1 = 3'd2,
    S_LO_0  = 3'd3,
    S_LO_1  = 3'd4,
    S_HI_0  = 3'd5,
    S_HI_1  = 3'd6,
    S_DONE  = 3'd7
  } state_t;

  state_t state, nxt;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:  nxt = din ? S_LAST1 : S_LAST0;
      S_LAST0: nxt = din ? S_LAST1 : S_LO_0;
      S_LAST1: nxt = din ? S_HI_1  : S_LAST0;
      S_LO_0:  nxt = din ? S_LO_1  : S_LO_0;
      S_LO_1:  nxt = din ? S_DONE  : S_LO_0;
      S_HI_0:  nxt = din ? S_HI_1  : S_DONE;
      S_HI_1:  nxt = din ? S_HI_1  : S_HI_0;
      S_DONE:  nxt = S_DONE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nxt;
  end

  assign hit = (state == S_DONE);

endmodule

module dual_run_checks (
  input logic clk,
  input logic rst,
  input logic din,
  input logic hit
);

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !hit);

  a_r4_sticky: assert property (@(posedge clk) disable iff (rst) hit |=> hit);

  a_r5_rise_needs_pair: assert property (@(posedge clk) disable iff (rst)
    $rose(hit) |-> ($past(din) == $past(din, 2)));

  a_r6_no_rise_after_change: assert property (@(posedge clk) disable iff (rst)
    (din != $past(din)) |=> !$rose(hit));

endmodule

bind dual_run_detector dual_run_checks u_chk (
  .clk(clk),
  .rst(rst),
  .din(din),
  .hit(hit)
);

// File: tb/sim_dual_run_detector.sv
`timescale 1ns/1ps
module sim_dual_run_detector;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic hit;

  int checks = 0;
  int errors = 0;

  int m_prev;
  bit m_lo, m_hi;

  always #5 clk = ~clk;

  dual_run_detector u0 (.clk(clk), .rst(rst), .din(din), .hit(hit));

  task automatic check(input logic exp, input string req);
    checks++;
    if (hit !== exp) begin
      errors++;
      $display("FAIL %s: hit=%b expected=%b at %0t", req, hit, exp, $time);
    end
  endtask

  task automatic do_reset(input string req);
    rst = 1'b1;
    @(posedge clk);
    m_prev = -1; m_lo = 0; m_hi = 0;
    #2;
    check(1'b0, req);
    rst = 1'b0;
  endtask

  task automatic send(input logic v, input string req);
    din = v;
    @(posedge clk);
    if (m_prev == int'(v)) begin
      if (v) m_hi = 1; else m_lo = 1;
    end
    m_prev = int'(v);
    #2;
    check(m_lo && m_hi, req);
  endtask

  task automatic send_str(input string s, input string req);
    for (int i = 0; i < s.len(); i++) send(s[i] == "1", req);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_prev = -1; m_lo = 0; m_hi = 0;
    @(posedge clk); @(posedge clk);
    #2;
    check(1'b0, "R1");
    rst = 1'b0;

    send_str("1100", "R2");       check(1'b1, "R2");
    do_reset("R10");
    send_str("0011", "R3");       check(1'b1, "R3");
    send_str("0101010011", "R4"); check(1'b1, "R4");
    do_reset("R10");
    send_str("001", "R5");        check(1'b0, "R5");
    send(1'b1, "R5");             check(1'b1, "R5");
    do_reset("R1");
    send_str("0101010101010101", "R6"); check(1'b0, "R6");
    do_reset("R1");
    send_str("1010101010101010", "R6"); check(1'b0, "R6");
    do_reset("R1");
    send_str("0001010100", "R7"); check(1'b0, "R7");
    do_reset("R1");
    send_str("1110101011", "R7"); check(1'b0, "R7");
    do_reset("R1");
    send_str("000111", "R8");     check(1'b1, "R8");
    do_reset("R1");
    send_str("1111010000", "R8"); check(1'b1, "R8");
    do_reset("R1");
    send_str("0010101", "R9");    check(1'b0, "R9");
    send(1'b1, "R9");             check(1'b1, "R9");
    do_reset("R10");
    send_str("0101", "R10");      check(1'b0, "R10");

    for (int seg = 0; seg < 300; seg++) begin
      do_reset("R1");
      for (int k = 0; k < 16; k++) send(1'($urandom_range(0, 1)), "R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule